// File: doc/BRIEF.md
# Serial-Loaded Quad Wiper Register Bank

This block is the digital front end of a four-channel, 64-step programmable resistor. A host shifts 8-bit update words into a serial register over a three-wire link: a select line (`cs_n`, active low), a bit clock (`sclk`) and a data line (`sdi`). The block ignores the length of a frame. When the select line returns high, the word now in the serial register is committed. Its two upper bits name one of four channels, and its six lower bits become that channel's wiper setting. Every channel other than the addressed one keeps its value. One frame changes one channel, so setting all four channels takes four frames.

The serial register also drives the `sdo` output. Several devices can therefore be chained, with each `sdo` feeding the next device's `sdi`. A shutdown input raises a status output and leaves the stored settings untouched.

The block runs on a single fabric clock `clk`. The three serial lines and the shutdown line are asynchronous to it. They pass through a two-stage synchronizer, and their edges are found in the `clk` domain. All outputs are registers. A synchronous active-high reset puts every channel at midscale.

Top module: `quad_wiper_bank`

## Requirements
- R1: At the first `clk` edge with `rst` high, all four settings become midscale (6'b100000, decimal 32), `sdo` becomes 0 and `shdn_stat` becomes 0.
- R2: A bit is shifted in, MSB first, only on a rising `sclk` edge while `cs_n` is low. `sdi` enters at bit 0 and the other bits move up one place. `sclk` edges while `cs_n` is high leave the serial register unchanged.
- R3: On a rising edge of `cs_n`, bits [7:6] of the serial register select the channel (00 = channel 0 at `wiper_flat[5:0]` … 11 = channel 3 at `wiper_flat[23:18]`). Bits [5:0] are written to that channel, and the other three channels keep their values.
- R4: A frame longer than eight bits commits only the last eight bits shifted in. Bits shifted in earlier have no effect on any setting.
- R5: On each falling `sclk` edge, `sdo` takes bit 7 of the serial register and holds it until the next falling edge.
- R6: While `shdn_n` is low, `shdn_stat` is 1, the settings hold their values, and frames are still accepted and committed. When `shdn_n` returns high, `shdn_stat` returns to 0.
- R7: An input change first seen at `clk` edge k takes effect on the outputs at edge k+2.
- R8: The settings do not change at any time other than the commit that follows a rising edge of `cs_n`, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock (asynchronous to clk) |
| cs_n | input | 1 | Active-low frame select; rising edge commits |
| sdi | input | 1 | Serial data in, MSB first |
| shdn_n | input | 1 | Active-low shutdown request |
| sdo | output | 1 | Serial register MSB, updated on falling sclk |
| shdn_stat | output | 1 | High while shutdown is requested |
| wiper_flat | output | 24 | Four 6-bit settings, channel 0 in the low bits |

## Verification
Every result appears at the second `clk` edge after the edge that first samples the input change. This covers a shifted bit, an `sdo` update, a committed setting and the shutdown status. The bench's reference model keeps a three-entry queue of sampled inputs and acts on the entry two edges old. Its predictions are compared on every falling `clk` edge, which is half a period after the design's registers update. The directed checks wait at least four cycles after a stimulus. One commit is also timed exactly: the old value is expected at the second falling edge after `cs_n` rises, and the new value at the third.

// File: rtl/wbank_pkg.sv
package wbank_pkg;

  // Sampled pin bundle, kept together so all lines see identical latency
  typedef struct packed {
    logic shdn_n;
    logic cs_n;
    logic sclk;
    logic sdi;
  } pin_vec_t;

  localparam pin_vec_t PINS_IDLE = '{shdn_n: 1'b1, cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

endpackage

// File: rtl/wbank_sync.sv
module wbank_sync #(
  parameter int          STAGES = 2,
  parameter int          W      = 4,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
      prev <= IDLE;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= din;
      prev   <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/wbank_shift.sv
module wbank_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              out_upd,
  output logic [WORD_W-1:0] word,
  output logic              sdo
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      sdo  <= 1'b0;
    end else begin
      if (shift_en) word <= {word[WORD_W-2:0], bit_in};
      if (out_upd)  sdo  <= word[WORD_W-1];
    end
  end

endmodule

// File: rtl/wbank_regs.sv
module wbank_regs #(
  parameter int NUM_CH = 4,
  parameter int VAL_W  = 6,
  parameter int ADDR_W = 2,
  parameter int WORD_W = ADDR_W + VAL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [WORD_W-1:0]       word,
  output logic [NUM_CH*VAL_W-1:0] wiper_flat
);

  localparam logic [VAL_W-1:0] MID = {1'b1, {(VAL_W-1){1'b0}}};

  logic [ADDR_W-1:0] addr;
  logic [VAL_W-1:0]  val;
  logic [NUM_CH-1:0] strobe;

  assign addr = word[WORD_W-1 -: ADDR_W];
  assign val  = word[VAL_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [VAL_W-1:0] setting;

    assign strobe[c] = commit && (addr == ADDR_W'(c));

    always_ff @(posedge clk) begin
      if (rst)            setting <= MID;
      else if (strobe[c]) setting <= val;
    end

    assign wiper_flat[c*VAL_W +: VAL_W] = setting;
  end

endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank #(
  parameter int NUM_CH      = 4,
  parameter int VAL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sclk,
  input  logic                    cs_n,
  input  logic                    sdi,
  input  logic                    shdn_n,
  output logic                    sdo,
  output logic                    shdn_stat,
  output logic [NUM_CH*VAL_W-1:0] wiper_flat
);
  import wbank_pkg::*;

  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W = ADDR_W + VAL_W;

  pin_vec_t pins_in, pins_lvl, pins_rise, pins_fall;
  logic     sdi_l, cs_l, shdn_l, sclk_rise, sclk_fall, commit, shift_en;
  logic [WORD_W-1:0] word;
  logic     unused_edges;

  assign pins_in = '{shdn_n: shdn_n, cs_n: cs_n, sclk: sclk, sdi: sdi};

  wbank_sync #(
    .STAGES (SYNC_STAGES),
    .W      ($bits(pin_vec_t)),
    .IDLE   (PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_in),
    .lvl  (pins_lvl),
    .rise (pins_rise),
    .fall (pins_fall)
  );

  assign sdi_l     = pins_lvl.sdi;
  assign cs_l      = pins_lvl.cs_n;
  assign shdn_l    = pins_lvl.shdn_n;
  assign sclk_rise = pins_rise.sclk;
  assign sclk_fall = pins_fall.sclk;
  assign commit    = pins_rise.cs_n;
  assign shift_en  = sclk_rise && !cs_l;
  assign unused_edges = ^{pins_rise.sdi, pins_rise.shdn_n, pins_fall.sdi,
                          pins_fall.shdn_n, pins_fall.cs_n, pins_lvl.sclk};

  wbank_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (sdi_l),
    .out_upd  (sclk_fall),
    .word     (word),
    .sdo      (sdo)
  );

  wbank_regs #(
    .NUM_CH (NUM_CH),
    .VAL_W  (VAL_W),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .word       (word),
    .wiper_flat (wiper_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) shdn_stat <= 1'b0;
    else     shdn_stat <= !shdn_l;
  end

endmodule

// File: rtl/wbank_chk.sv
module wbank_chk #(
  parameter int NUM_CH = 4,
  parameter int VAL_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sdi_l,
  input logic                    cs_l,
  input logic                    shdn_l,
  input logic                    sclk_rise,
  input logic                    sclk_fall,
  input logic                    commit,
  input logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)+VAL_W-1:0] word,
  input logic                    sdo,
  input logic                    shdn_stat,
  input logic [NUM_CH*VAL_W-1:0] wiper_flat
);

  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W = ADDR_W + VAL_W;
  localparam logic [VAL_W-1:0] MID = {1'b1, {(VAL_W-1){1'b0}}};

  logic              rst_q = 1'b0;
  logic [ADDR_W-1:0] ch_q  = '0;
  logic [VAL_W-1:0]  sel;

  always @(posedge clk) begin
    if (rst_q) begin
      p_mid_after_reset_r1: assert (wiper_flat == {NUM_CH{MID}} && !sdo && !shdn_stat)
        else $error("reset state wrong");
    end
    rst_q <= rst;
    ch_q  <= word[WORD_W-1 -: ADDR_W];
  end

  always_comb sel = wiper_flat[int'(ch_q)*VAL_W +: VAL_W];

  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !cs_l) |=> (word == {$past(word[WORD_W-2:0]), $past(sdi_l)}));

  p_no_shift_r2: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise && !cs_l) |=> $stable(word));

  p_commit_value_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (sel == $past(word[VAL_W-1:0])));

  p_sdo_tap_r5: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |=> (sdo == $past(word[WORD_W-1])));

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(sdo));

  p_shdn_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(shdn_l) |=> shdn_stat);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(wiper_flat));

endmodule

bind quad_wiper_bank wbank_chk #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sdi_l      (sdi_l),
  .cs_l       (cs_l),
  .shdn_l     (shdn_l),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall),
  .commit     (commit),
  .word       (word),
  .sdo        (sdo),
  .shdn_stat  (shdn_stat),
  .wiper_flat (wiper_flat)
);

// File: tb/quad_wiper_bank_test.sv
module quad_wiper_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, shdn_n = 1'b1;
  logic        sdo, shdn_stat;
  logic [23:0] wiper_flat;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  quad_wiper_bank uut (
    .clk (clk), .rst (rst), .sclk (sclk), .cs_n (cs_n), .sdi (sdi),
    .shdn_n (shdn_n), .sdo (sdo), .shdn_stat (shdn_stat), .wiper_flat (wiper_flat)
  );

  always #5 clk = ~clk;

  // Reference model: queue of sampled pins {shdn_n, cs_n, sclk, sdi}, newest first
  logic [3:0] hq[$];
  int         m_set[4];
  logic [7:0] m_word;
  logic       m_sdo, m_shdn;
  bit         m_valid = 0;

  always @(posedge clk) begin
    logic [3:0] a, b;
    if (rst) begin
      for (int c = 0; c < 4; c++) m_set[c] = 32;
      m_word = 8'h00; m_sdo = 1'b0; m_shdn = 1'b0;
      hq = '{4'b1100, 4'b1100, 4'b1100};
      m_valid = 1;
    end else if (m_valid) begin
      a = hq[1];
      b = hq[2];
      if (~a[1] && b[1]) m_sdo = m_word[7];
      if (a[1] && !b[1] && !a[2]) m_word = {m_word[6:0], a[0]};
      if (a[2] && !b[2]) m_set[m_word[7:6]] = int'(m_word[5:0]);
      m_shdn = !a[3];
      hq.push_front({shdn_n, cs_n, sclk, sdi});
      void'(hq.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R7: per-cycle comparison against the model, sampled away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R7 model", {6'd0, sdo, shdn_stat, wiper_flat},
          {6'd0, m_sdo, m_shdn, 6'(m_set[3]), 6'(m_set[2]), 6'(m_set[1]), 6'(m_set[0])});
    end
  end

  function automatic logic [31:0] ch(input int c);
    return {26'd0, wiper_flat[c*6 +: 6]};
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nbits of data MSB first; optionally check sdo after each falling edge
  task automatic frame(input logic [31:0] data, input int nbits, input bit close,
                       input bit chk_sdo, input logic [7:0] prev);
    logic [15:0] comb;
    comb = {prev, data[7:0]};
    cs_n = 1'b0;
    waitn(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = data[i];
      waitn(4);
      sclk = 1'b1;
      waitn(4);
      sclk = 1'b0;
      waitn(4);
      if (chk_sdo) chk("R5 sdo tap", {31'd0, sdo}, {31'd0, comb[15-(nbits-i)]});
    end
    if (close) begin
      cs_n = 1'b1;
      waitn(6);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    waitn(5);
    rst = 1'b0;
    waitn(2);
    // R1 reset state
    for (int c = 0; c < 4; c++) chk("R1 midscale", ch(c), 32);
    chk("R1 sdo", {31'd0, sdo}, 0);
    chk("R1 shdn_stat", {31'd0, shdn_stat}, 0);

    // R3 one channel per frame
    frame(32'h15, 8, 1, 0, 8'h00);
    chk("R3 ch0", ch(0), 21);
    chk("R3 ch1 untouched", ch(1), 32);
    frame(32'h6A, 8, 1, 0, 8'h00);
    chk("R3 ch1", ch(1), 42);
    frame(32'h81, 8, 1, 0, 8'h00);
    chk("R3 ch2", ch(2), 1);
    chk("R3 ch3 untouched", ch(3), 32);
    // R5 sdo streams the previous word then the new one
    frame(32'hFE, 8, 1, 1, 8'h81);
    chk("R3 ch3", ch(3), 62);
    chk("R3 ch0 kept", ch(0), 21);

    // R4 long frame keeps only the last eight bits
    frame(32'hFF87, 16, 1, 0, 8'h00);
    chk("R4 ch2 from tail", ch(2), 7);
    chk("R4 ch3 not from head", ch(3), 62);

    // R2 sclk with cs_n high is ignored; empty frame recommits old word
    sdi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; waitn(4);
      sclk = 1'b0; waitn(4);
    end
    cs_n = 1'b0; waitn(8);
    cs_n = 1'b1; waitn(6);
    chk("R2 ch3 unchanged", ch(3), 62);
    chk("R2 ch2 recommit", ch(2), 7);

    // R8 no change mid-frame
    frame(32'h4, 4, 0, 0, 8'h00);
    chk("R8 ch0 mid", ch(0), 21);
    chk("R8 ch1 mid", ch(1), 42);
    chk("R8 ch2 mid", ch(2), 7);
    chk("R8 ch3 mid", ch(3), 62);
    frame(32'hC, 4, 1, 0, 8'h00);
    chk("R8 ch1 after commit", ch(1), 12);

    // R6 shutdown
    shdn_n = 1'b0;
    waitn(6);
    chk("R6 shdn_stat high", {31'd0, shdn_stat}, 1);
    chk("R6 ch0 retained", ch(0), 21);
    frame(32'h03, 8, 1, 0, 8'h00);
    chk("R6 write in shutdown", ch(0), 3);
    chk("R6 still shut", {31'd0, shdn_stat}, 1);
    shdn_n = 1'b1;
    waitn(6);
    chk("R6 shdn_stat low", {31'd0, shdn_stat}, 0);

    // R7 exact commit latency
    frame(32'h7F, 8, 0, 0, 8'h00);
    cs_n = 1'b1;
    waitn(2);
    chk("R7 old before edge k+2", ch(1), 12);
    waitn(1);
    chk("R7 new at edge k+2", ch(1), 63);
    waitn(4);

    // R1 reset again mid-run
    rst = 1'b1;
    waitn(3);
    rst = 1'b0;
    waitn(1);
    for (int c = 0; c < 4; c++) chk("R1 midscale again", ch(c), 32);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule